// File: doc/BRIEF.md
# Full-Duplex Serial Word Master

This block is the master end of a four-wire synchronous serial link to one peripheral. It owns the serial clock and an active-low select. It exchanges one word per transfer: the master sends a bit and takes one in on every serial clock cycle.

A host drives the outgoing word, the configuration and a start strobe. It gets back a received word, qualified by a one-cycle done pulse. The host picks the following at the start of each transfer:

- the clock idle level
- the clock phase
- the bit order (most significant bit first or least significant bit first)
- the word length, from 4 to 32 bits
- the half-period of the serial clock, in system clocks
- a settle delay between select going low and the first clock edge

A continue input lets the host chain words under one select assertion. The serial clock is built from the system clock. Every output comes straight from a flip-flop.

Top module: `spi_xfer_master`

## Requirements
- R1: After synchronous reset, cs_n is 1, busy is 0, done is 0 and sclk is 0.
- R2: While no transfer is active, sclk follows the clock-idle input: 0 when cpol is 0, 1 when cpol is 1.
- R3: Every serial clock cycle moves one bit each way. After a word of N bits, rx_word holds the N bits the peripheral sent, and the peripheral has received the N low bits of tx_word. This holds in all four combinations of cpol and cpha.
- R4: With cpha=0, mosi carries the first bit in the cycle after select falls, before any clock edge. Bits change on edges that return sclk to idle and are sampled on edges that leave idle.
- R5: With cpha=1, the first bit appears on the first edge leaving idle. Bits change on edges leaving idle and are sampled on edges returning to idle.
- R6: With lsb_first=0, word bit N-1 goes first, and the first bit received lands in rx_word bit N-1. With lsb_first=1, bit 0 goes first, and the first bit received lands in bit 0.
- R7: A word of length N produces exactly 2N sclk transitions, and sclk ends at its idle level. word_len values below 4 act as 4, and values above 32 act as 32.
- R8: The first sclk transition comes exactly setup_len + H system clocks after the edge that drops cs_n, where H is half_div. Every later half period is H clocks. A half_div of 0 acts as 1.
- R9: busy rises with select on an accepted start. A start seen while busy is ignored: no second transfer follows and the word in flight is unchanged.
- R10: done is high for exactly one cycle per word, with rx_word valid in that cycle. On the final word, cs_n returns to 1 and busy falls in the same cycle.
- R11: If cont is 1 at the clock edge that raises done, select stays low. tx_word at that edge is loaded as the next word, with the same configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| cont | input | 1 | Chain another word at word end |
| tx_word | input | MAX_W | Word to send |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Send and receive least significant bit first |
| word_len | input | LEN_W | Bits per word (4..MAX_W) |
| half_div | input | DIV_W | Serial clock half period in system clocks |
| setup_len | input | SET_W | Clocks from select to the first half period |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle word-complete pulse |
| rx_word | output | MAX_W | Last received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
A wrong edge counter shows at the ports within one word. The sclk transition count and the end-of-word done both move. A wrong sample/drive phase or bit index corrupts rx_word and the peripheral's captured word, and that is seen at the very next done pulse. A stuck divider or settle counter shifts the first sclk edge away from setup_len plus the half period, so the cycle count from cs_n falling exposes it before any data moves. A bad chaining decision shows as cs_n rising between words.

// File: rtl/spi_xm_pkg.sv
package spi_xm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } xm_state_e;

endpackage

// File: rtl/spi_xm_clkgen.sv
module spi_xm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // One tick per half period of the serial clock
  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_xm_shifter.sv
module spi_xm_shifter #(
  parameter int MAX_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAX_W-1:0] load_val,
  input  logic             shift,
  input  logic             in_bit,
  input  logic             lsb_first,
  input  logic [LEN_W-1:0] len,
  output logic             out_bit,
  output logic [MAX_W-1:0] word
);

  logic [MAX_W-1:0] sh;
  logic [MAX_W-1:0] nxt_msb;
  logic [MAX_W-1:0] nxt_lsb;
  logic [MAX_W-1:0] mask;
  logic [MAX_W:0]   sh_pad;
  logic             top_bit;

  assign sh_pad = {1'b0, sh};

  // Per-bit next-state for both shift directions
  for (genvar i = 0; i < MAX_W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign nxt_msb[i] = in_bit;
    end else begin : g_rest
      assign nxt_msb[i] = sh[i-1];
    end
    assign nxt_lsb[i] = (int'(len) - 1 == i) ? in_bit : sh_pad[i+1];
    assign mask[i]    = (i < int'(len));
  end

  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < MAX_W; i++) begin
      if (int'(len) - 1 == i) top_bit = sh[i];
    end
  end

  assign out_bit = lsb_first ? sh[0] : top_bit;
  assign word    = sh & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (load) begin
      sh <= load_val;
    end else if (shift) begin
      sh <= lsb_first ? nxt_lsb : nxt_msb;
    end
  end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xm_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int MIN_W = 4,
  parameter int DIV_W = 8,
  parameter int SET_W = 8,
  localparam int LEN_W  = $clog2(MAX_W + 1),
  localparam int ECNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cont,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [LEN_W-1:0] word_len,
  input  logic [DIV_W-1:0] half_div,
  input  logic [SET_W-1:0] setup_len,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [MAX_W-1:0] rx_word,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi
);

  xm_state_e         state;
  logic              c_cpol, c_cpha, c_lsb;
  logic [LEN_W-1:0]  c_len;
  logic [DIV_W-1:0]  c_half;
  logic [SET_W-1:0]  c_setup;
  logic [SET_W-1:0]  scnt;
  logic [ECNT_W-1:0] ecnt;

  logic [LEN_W-1:0]  len_eff;
  logic [DIV_W-1:0]  half_eff;
  logic              accept, chain;
  logic [LEN_W-1:0]  ld_len;
  logic              ld_lsb;
  logic              ld_top, ld_first;
  logic              run, tick;
  logic              sample_edge, last_edge;
  logic              sh_load, sh_shift, sh_out;
  logic [MAX_W-1:0]  sh_word;

  // Configuration clamping
  always_comb begin
    len_eff = word_len;
    if (word_len < LEN_W'(MIN_W))      len_eff = LEN_W'(MIN_W);
    else if (word_len > LEN_W'(MAX_W)) len_eff = LEN_W'(MAX_W);
    half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  end

  assign accept = (state == ST_IDLE) && start;
  assign chain  = (state == ST_FIN) && cont;
  assign ld_len = accept ? len_eff : c_len;
  assign ld_lsb = accept ? lsb_first : c_lsb;

  // First outgoing bit of a word being loaded
  always_comb begin
    ld_top = 1'b0;
    for (int i = 0; i < MAX_W; i++) begin
      if (int'(ld_len) - 1 == i) ld_top = tx_word[i];
    end
  end
  assign ld_first = ld_lsb ? tx_word[0] : ld_top;

  assign run         = (state == ST_RUN);
  assign sample_edge = (~ecnt[0]) ^ c_cpha;
  assign last_edge   = (ecnt == ({c_len, 1'b0} - ECNT_W'(1)));
  assign sh_load     = accept || chain;
  assign sh_shift    = run && tick && sample_edge;

  spi_xm_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .half (c_half),
    .tick (tick)
  );

  spi_xm_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) shifter_i (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_val  (tx_word),
    .shift     (sh_shift),
    .in_bit    (miso),
    .lsb_first (c_lsb),
    .len       (c_len),
    .out_bit   (sh_out),
    .word      (sh_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
      c_cpol  <= 1'b0;
      c_cpha  <= 1'b0;
      c_lsb   <= 1'b0;
      c_len   <= LEN_W'(MIN_W);
      c_half  <= DIV_W'(1);
      c_setup <= '0;
      scnt    <= '0;
      ecnt    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (start) begin
            c_cpol  <= cpol;
            c_cpha  <= cpha;
            c_lsb   <= lsb_first;
            c_len   <= len_eff;
            c_half  <= half_eff;
            c_setup <= setup_len;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            scnt    <= '0;
            ecnt    <= '0;
            if (!cpha) mosi <= ld_first;
            state <= (setup_len == '0) ? ST_RUN : ST_SETUP;
          end
        end
        ST_SETUP: begin
          scnt <= scnt + SET_W'(1);
          if (scnt == c_setup - SET_W'(1)) state <= ST_RUN;
        end
        ST_RUN: begin
          if (tick) begin
            sclk <= ~sclk;
            ecnt <= ecnt + ECNT_W'(1);
            if (!sample_edge && !last_edge) mosi <= sh_out;
            if (last_edge) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          done    <= 1'b1;
          rx_word <= sh_word;
          ecnt    <= '0;
          sclk    <= c_cpol;
          if (cont) begin
            if (!c_cpha) mosi <= ld_first;
            state <= ST_RUN;
          end else begin
            cs_n  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xm_check.sv
module spi_xm_check (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cpol,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk
);

  // R2: idle clock level follows cpol
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && !busy && !$past(busy) && !$past(rst)) |-> (sclk == $past(cpol)));

  // R9: select only while busy
  a_r9_select_busy: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R9: busy only rises on a start
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: select released only with done
  a_r10_release_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  // R10: busy falls together with done and released select
  a_r10_idle_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && cs_n));

endmodule

bind spi_xfer_master spi_xm_check chk_i (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .cpol  (cpol),
  .busy  (busy),
  .done  (done),
  .cs_n  (cs_n),
  .sclk  (sclk)
);

// File: tb/spi_xfer_master_tb_top.sv
module spi_xfer_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, cont = 1'b0;
  logic [31:0] tx_word = '0;
  logic        cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [5:0]  word_len = 6'd8;
  logic [7:0]  half_div = 8'd2;
  logic [7:0]  setup_len = 8'd0;
  logic        miso = 1'b0;
  logic        busy, done, sclk, cs_n, mosi;
  logic [31:0] rx_word;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_xfer_master dut_i (
    .clk(clk), .rst(rst), .start(start), .cont(cont), .tx_word(tx_word),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .word_len(word_len),
    .half_div(half_div), .setup_len(setup_len), .miso(miso),
    .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi)
  );

  // Peripheral model
  logic [31:0] sw [0:3];
  logic [31:0] cap [0:3];
  int s_len = 8;
  bit s_cpol = 0, s_cpha = 0, s_lsb = 0;
  int kd = 0, wd = 0, ks = 0, ws = 0;

  function automatic logic pick(logic [31:0] w, int k);
    return s_lsb ? w[k] : w[s_len-1-k];
  endfunction

  always @(negedge cs_n) begin
    kd = 0; wd = 0; ks = 0; ws = 0;
    if (!s_cpha) miso = pick(sw[0], 0);
  end

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      if (((sclk != s_cpol) ? 1'b1 : 1'b0) ^ s_cpha) begin
        cap[ws][s_lsb ? ks : s_len-1-ks] = mosi;
        ks++;
        if (ks == s_len) begin ks = 0; ws++; end
      end else if (!s_cpha) begin
        kd++;
        if (kd == s_len) begin kd = 0; wd++; end
        miso = pick(sw[wd], kd);
      end else begin
        miso = pick(sw[wd], kd);
        kd++;
        if (kd == s_len) begin kd = 0; wd++; end
      end
    end
  end

  // Port monitor
  bit prev_cs = 1, prev_sclk = 0, got = 0;
  int cyc = 0, togg = 0, first_delay = 0, rises = 0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      cyc = 0; got = 0; togg = 0;
    end else if (!cs_n) begin
      cyc++;
      if (sclk != prev_sclk) begin
        togg++;
        if (!got) begin first_delay = cyc; got = 1; end
      end
    end
    if (!prev_cs && cs_n) rises++;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic setup_cfg(int cp, int ph, int lsb, int lenreq, int lenexp, int half, int stp);
    cpol = cp[0]; cpha = ph[0]; lsb_first = lsb[0];
    word_len = 6'(lenreq); half_div = 8'(half); setup_len = 8'(stp);
    s_cpol = cp[0]; s_cpha = ph[0]; s_lsb = lsb[0]; s_len = lenexp;
    for (int i = 0; i < 4; i++) cap[i] = '0;
    @(negedge clk); @(negedge clk);
    chk(sclk == cp[0], "R2 idle level", 32'(sclk), 32'(cp));
  endtask

  task automatic xfer(int cp, int ph, int lsb, int lenreq, int lenexp, int half, int stp,
                      logic [31:0] t, logic [31:0] s);
    logic [31:0] m;
    int h;
    m = lmask(lenexp);
    h = (half == 0) ? 1 : half;
    sw[0] = s;
    setup_cfg(cp, ph, lsb, lenreq, lenexp, half, stp);
    tx_word = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cs_n == 1'b0, "R9 busy with select", 32'(busy), 32'h1);
    if (ph == 0)  // R4: first bit present before any edge
      chk(mosi == (lsb ? t[0] : t[lenexp-1]), "R4 first bit", 32'(mosi), 32'(lsb ? t[0] : t[lenexp-1]));
    while (!done) @(negedge clk);
    chk(rx_word == (s & m), lsb ? "R6 R3 rx lsb-first" : "R3 R5 rx word", rx_word, s & m);
    chk(cap[0] == (t & m), lsb ? "R6 R3 tx lsb-first" : "R3 R5 tx word", cap[0], t & m);
    chk(togg == 2 * lenexp, "R7 edge count", 32'(togg), 32'(2 * lenexp));
    chk(first_delay == stp + h, "R8 first edge timing", 32'(first_delay), 32'(stp + h));
    chk(cs_n == 1'b1 && busy == 1'b0, "R10 release with done", {cs_n, busy}, 32'h2);
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", 32'(done), 32'h0);
    chk(sclk == cp[0], "R7 ends at idle", 32'(sclk), 32'(cp));
  endtask

  task automatic chain3(int cp, int ph, int lsb, logic [31:0] base);
    logic [31:0] t [0:2];
    int r0;
    for (int i = 0; i < 3; i++) begin
      t[i]  = (base + 32'(i) * 32'h3B) & 32'hFF;
      sw[i] = (~base ^ (32'(i) * 32'h65)) & 32'hFF;
    end
    setup_cfg(cp, ph, lsb, 8, 8, 2, 1);
    r0 = rises;
    tx_word = t[0]; cont = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tx_word = t[1];
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      while (!done) @(negedge clk);
      chk(rx_word == sw[w], "R11 chained rx", rx_word, sw[w]);
      if (w < 2) chk(cs_n == 1'b0, "R11 select held", 32'(cs_n), 32'h0);
      else       chk(cs_n == 1'b1, "R10 final release", 32'(cs_n), 32'h1);
      if (w == 0) tx_word = t[2];
      if (w == 1) cont = 1'b0;
    end
    @(negedge clk);
    for (int w = 0; w < 3; w++)
      chk(cap[w] == t[w], "R11 chained tx", cap[w], t[w]);
    chk(rises == r0 + 1, "R11 one release", 32'(rises - r0), 32'h1);
    chk(togg == 48, "R11 R7 chained edges", 32'(togg), 32'd48);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [0:3];
    int idx;
    lens[0] = 4; lens[1] = 7; lens[2] = 16; lens[3] = 32;
    for (int i = 0; i < 4; i++) sw[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0 && sclk == 1'b0,
        "R1 reset state", {cs_n, busy, done, sclk}, 32'h8);

    // Sweep over modes, bit order, lengths
    idx = 0;
    for (int md = 0; md < 4; md++) begin
      for (int lb = 0; lb < 2; lb++) begin
        for (int li = 0; li < 4; li++) begin
          xfer(md >> 1, md & 1, lb, lens[li], lens[li], (idx % 3) + 1, idx % 4,
               32'hA5C3_96E1 ^ (32'(idx) * 32'h0101_0203),
               32'h3C5A_F00F + (32'(idx) * 32'h1111_1111));
          idx++;
        end
      end
    end

    // R7 / R8 clamping
    xfer(0, 1, 0, 2, 4, 0, 0, 32'h0000_000B, 32'h0000_0006);
    xfer(1, 0, 1, 40, 32, 3, 2, 32'hDEAD_BEEF, 32'h1234_5678);

    // R9 start while busy is ignored
    sw[0] = 32'h96;
    setup_cfg(0, 0, 0, 8, 8, 2, 0);
    tx_word = 32'h5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    tx_word = 32'hC3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(cap[0] == 32'h5A, "R9 word unchanged", cap[0], 32'h5A);
    chk(rx_word == 32'h96, "R9 rx unchanged", rx_word, 32'h96);
    chk(togg == 16, "R9 no extra edges", 32'(togg), 32'd16);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1, "R9 no queued start", {busy, cs_n}, 32'h1);

    // R11 chaining in two modes
    chain3(1, 1, 0, 32'h4D);
    chain3(0, 0, 1, 32'hB2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule